// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A table is addressed by a slice of low-order bits of the instruction address, with no tag compare, so unrelated branches whose addresses share that slice share an entry. Each entry holds several saturating counters. A global register records the outcomes of the most recent resolved branches, and that history chooses which counter of the entry supplies the prediction.

On the fetch side, the front end presents an address and receives a taken/not-taken guess in the same cycle, together with the history value that chose the counter. The front end keeps that history with the branch. When the branch resolves, it returns the branch address, the saved history and the real outcome. One clock edge later, only the counter named by that address and history has moved one step toward the outcome, and the outcome has been shifted into the global history.

The history length `HIST_BITS`, the counter width `CTR_BITS` and the entry count `ENTRIES` are module parameters. Their defaults are one history bit, two-bit counters and 1024 entries.

Top module: `corr_bpred`

## Requirements
- R1: The entry index is `pc[PC_LSB +: log2(ENTRIES)]` (bits 11:2 of the address by default), and no tag compare is done. Two addresses that differ only above the index slice (for example, by `ENTRIES*4`) share all of their counters.
- R2: Reset sets every counter to weakly not-taken, which is 2^(CTR_BITS-1)-1 (value 1 for two-bit counters), and sets the global history to all zeros.
- R3: `fetch_taken` is 1 exactly when the selected counter is at or above 2^(CTR_BITS-1). For two-bit counters, this means values 2 and 3.
- R4: A resolved taken branch raises the selected counter by one, saturating at 2^CTR_BITS-1. A resolved not-taken branch lowers it by one, saturating at 0.
- R5: A counter at its strong taken value needs two consecutive not-taken outcomes before its prediction changes to not-taken.
- R6: A resolve updates only the counter that `res_hist` selects in the entry of `res_pc`. The other counters of that entry, and the counters of other entries, keep their values.
- R7: When `res_valid` is high, the global history becomes `{history[HIST_BITS-2:0], res_taken}` at the next edge, so bit 0 holds the newest outcome. When `res_valid` is low, the history does not change. `res_hist` never feeds the history.
- R8: `fetch_hist` shows the current global history, and the fetch prediction uses the counter that this history selects.
- R9: If a resolve and a lookup address the same counter in the same cycle, the lookup returns the value from before the update. The updated value appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_taken | output | 1 | Predicted direction, 1 = taken |
| fetch_hist | output | HIST_BITS | Global history used for this prediction |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_hist | input | HIST_BITS | History saved at prediction time |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives one counter through its full range in both directions. A counter that wraps instead of saturating shows up as a taken prediction after a run of not-taken outcomes, or as a not-taken prediction after a run of taken outcomes. It trains one history selector of an entry and then reads the other one back. A design that ignored `res_hist`, or used the live history on update, would leak training into the wrong counter. It also presents an update and a lookup of the same counter in one cycle, which catches a forwarded read, and it aliases two addresses above the index slice. Finally, it checks that the history takes the outcome and not the supplied history bits, and that it holds still while no resolve is presented.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // One saturating step of a counter whose largest value is top_val.
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input int unsigned top_val,
                                           input logic        up);
    if (up) return (cur >= top_val) ? top_val : cur + 1;
    else    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Direction carried by a counter of the given width.
  function automatic logic says_taken(input int unsigned cur,
                                      input int unsigned bits);
    return cur >= (32'd1 << (bits - 1));
  endfunction

  // Weakest not-taken value for a counter of the given width.
  function automatic int unsigned weak_not_taken(input int unsigned bits);
    return (32'd1 << (bits - 1)) - 1;
  endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
  parameter int HW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [HW-1:0] hist
);
  logic [HW-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= HW'({hist_q, bit_in});
  end

  assign hist = hist_q;
endmodule

// File: rtl/cbp_table.sv
module cbp_table
  import cbp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int HW    = 1,
  parameter int CW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [HW-1:0]    rd_sel,
  output logic [CW-1:0]    rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [HW-1:0]    wr_sel,
  input  logic             wr_taken,
  output logic [CW-1:0]    wr_old,
  output logic [CW-1:0]    wr_new
);
  localparam int AW = IDX_W + HW;
  localparam int ROWS = 1 << AW;
  localparam int unsigned CTR_MAX = (32'd1 << CW) - 1;
  localparam logic [CW-1:0] CTR_INIT = CW'(weak_not_taken(CW));

  logic [CW-1:0] ctr_q [ROWS];
  logic [AW-1:0] rd_addr, wr_addr;

  assign rd_addr = {rd_idx, rd_sel};
  assign wr_addr = {wr_idx, wr_sel};

  // The read is taken straight from the storage, so it returns the
  // value held before any update landing on the same edge.
  assign rd_ctr = ctr_q[rd_addr];
  assign wr_old = ctr_q[wr_addr];
  assign wr_new = CW'(sat_step(32'(wr_old), CTR_MAX, wr_taken));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_addr] <= wr_new;
    end
  end
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import cbp_pkg::*;
#(
  parameter int ENTRIES   = 1024,
  parameter int HIST_BITS = 1,
  parameter int CTR_BITS  = 2,
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      fetch_pc,
  output logic                 fetch_taken,
  output logic [HIST_BITS-1:0] fetch_hist,
  input  logic                 res_valid,
  input  logic [PC_W-1:0]      res_pc,
  input  logic [HIST_BITS-1:0] res_hist,
  input  logic                 res_taken
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0]    fetch_idx, res_idx;
  logic [HIST_BITS-1:0] ghist;
  logic [CTR_BITS-1:0]  fetch_ctr;
  // Named events for the checker.
  logic                 upd_fire;
  logic [CTR_BITS-1:0]  upd_old, upd_new;
  logic                 unused_pc_bits;

  assign fetch_idx = fetch_pc[PC_LSB +: IDX_W];
  assign res_idx   = res_pc[PC_LSB +: IDX_W];
  assign upd_fire  = res_valid;
  assign unused_pc_bits = ^{fetch_pc, res_pc};

  cbp_history #(.HW(HIST_BITS)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (res_valid),
    .bit_in   (res_taken),
    .hist     (ghist)
  );

  cbp_table #(.IDX_W(IDX_W), .HW(HIST_BITS), .CW(CTR_BITS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (fetch_idx),
    .rd_sel   (ghist),
    .rd_ctr   (fetch_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (res_idx),
    .wr_sel   (res_hist),
    .wr_taken (res_taken),
    .wr_old   (upd_old),
    .wr_new   (upd_new)
  );

  assign fetch_taken = says_taken(32'(fetch_ctr), CTR_BITS);
  assign fetch_hist  = ghist;
endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int HW = 1,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic          res_taken,
  input logic [HW-1:0] fetch_hist,
  input logic          upd_fire,
  input logic [CW-1:0] upd_old,
  input logic [CW-1:0] upd_new
);
  // R2
  hist_reset_chk: assert property (@(posedge clk)
    !rst_n |=> fetch_hist == '0);

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> fetch_hist == HW'({$past(fetch_hist), $past(res_taken)}));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(fetch_hist));

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> (upd_new == upd_old) || (upd_new == upd_old + 1'b1)
                 || (upd_new == upd_old - 1'b1));

  // R4
  step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && res_taken) |-> upd_new >= upd_old);

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !res_taken) |-> upd_new <= upd_old);
endmodule

bind corr_bpred corr_bpred_chk #(.HW(HIST_BITS), .CW(CTR_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_taken  (res_taken),
  .fetch_hist (fetch_hist),
  .upd_fire   (upd_fire),
  .upd_old    (upd_old),
  .upd_new    (upd_new)
);

// File: tb/corr_bpred_test.sv
`timescale 1ns/1ps
module corr_bpred_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_taken;
  logic [0:0]  fetch_hist;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic [0:0]  res_hist = '0;
  logic        res_taken = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] SCR = 32'h0000_0F00;
  localparam logic [31:0] PA  = 32'h0000_0100;
  localparam logic [31:0] PB  = 32'h0000_0200;
  localparam logic [31:0] PC0 = 32'h0000_0300;
  localparam logic [31:0] PD  = 32'h0000_0400;

  corr_bpred uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(fetch_taken),
    .fetch_hist(fetch_hist), .res_valid(res_valid), .res_pc(res_pc),
    .res_hist(res_hist), .res_taken(res_taken)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic resolve(input logic [31:0] pc, input logic h, input logic t);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_hist = h; res_taken = t;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // Bring global history to a chosen value using the scratch entry only.
  task automatic set_hist(input logic h);
    resolve(SCR, 1'b0, h);
  endtask

  task automatic peek(input string req, input logic [31:0] pc, input logic sel, input logic exp);
    set_hist(sel);
    fetch_pc = pc;
    #1;
    chk(req, 32'(fetch_taken), 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R2 history", 32'(fetch_hist), 0);
    fetch_pc = PA; #1;
    chk("R2 counter A", 32'(fetch_taken), 0);
    fetch_pc = PD; #1;
    chk("R2 counter D", 32'(fetch_taken), 0);
  endtask

  task automatic t_counter;
    resolve(PA, 1'b0, 1'b1);              // 1 -> 2
    peek("R3 value 2 taken", PA, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) resolve(PA, 1'b0, 1'b1);  // saturate at 3
    resolve(PA, 1'b0, 1'b0);              // 3 -> 2
    peek("R5 one miss keeps taken / R4 upper saturation", PA, 1'b0, 1'b1);
    resolve(PA, 1'b0, 1'b0);              // 2 -> 1
    peek("R5 two misses flip", PA, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) resolve(PA, 1'b0, 1'b0);  // saturate at 0
    resolve(PA, 1'b0, 1'b1);              // 0 -> 1
    peek("R4 lower saturation", PA, 1'b0, 1'b0);
    resolve(PA, 1'b0, 1'b1);              // 1 -> 2
    peek("R3 threshold", PA, 1'b0, 1'b1);
  endtask

  task automatic t_select;
    resolve(PB, 1'b1, 1'b1);
    resolve(PB, 1'b1, 1'b1);              // sel1 -> 3
    peek("R8 selected by history 1", PB, 1'b1, 1'b1);
    peek("R6 other selector untouched", PB, 1'b0, 1'b0);
    peek("R6 other entry untouched", PD, 1'b1, 1'b0);
  endtask

  task automatic t_history;
    resolve(SCR, 1'b0, 1'b1);
    @(negedge clk); #1;
    chk("R7 newest outcome 1", 32'(fetch_hist), 1);
    resolve(SCR, 1'b1, 1'b0);
    #1;
    chk("R7 outcome not res_hist", 32'(fetch_hist), 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R7 hold while idle", 32'(fetch_hist), 0);
  endtask

  task automatic t_alias;
    resolve(PC0, 1'b0, 1'b1);
    peek("R1 alias shares entry", PC0 + 32'd4096, 1'b0, 1'b1);
    peek("R1 neighbour index separate", PC0 + 32'd4, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle;
    set_hist(1'b0);
    @(negedge clk);
    res_valid = 1'b1; res_pc = PD; res_hist = 1'b0; res_taken = 1'b1;
    fetch_pc = PD;
    #1;
    chk("R9 pre-update read", 32'(fetch_taken), 0);
    @(negedge clk);
    res_valid = 1'b0;
    peek("R9 update visible later", PD, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_counter();
    t_select();
    t_history();
    t_alias();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule